// File: doc/BRIEF.md
# NAND Page Copy-Back Sequencer

This block sits on the host side of a raw NAND flash bus. It copies one page of the device to another page without moving the page data across the bus. A single request carries a source and a destination byte address. The sequencer first issues a page read. This loads the source page, 528 bytes, into the device's own page register, and no data bytes are read out. The sequencer then waits for the ready/busy line. Next it issues the copy-back program with the destination address, so the device writes its page register back into the array. It waits on ready/busy again, and then reads one status byte. I/O0 of that byte gives the outcome.

Every bus byte is placed by a write-enable pulse whose low and high phases are each a parameterised number of clock cycles. The command-latch or address-latch strobe is held high for the whole byte. The status byte is fetched with one read-enable pulse of the same width. Before anything is driven, the request is checked for a plane match: the plane bit of both addresses must be equal, because the device can only copy within a plane. A stuck busy line ends the operation with a timeout. A small table remembers the pages that have been copy-back destinations, so the host can ask whether a later partial-page program to a page would break the program-once rule. Erasing a block clears the entries that belong to it.

Top module: `nand_copyback_seq`

## Requirements
- R1: An accepted request produces exactly nine bus bytes, in this order: command 0x00 (cle high), three source address bytes (ale high), command 0x8A (cle high), three destination address bytes (ale high), and command 0x70 (cle high). Each byte is latched by the device on a rising edge of weN.
- R2: Each address is sent in three bytes. The first byte is bits 7..0. The second byte is bits 16..9. The third byte is bits 24..17. Bit 8 is never sent.
- R3: Command 0x8A is never latched while rbN is low. After each address phase, the block ignores rbN for WAIT_BLIND cycles, and it then proceeds only when rbN is high.
- R4: reN pulses low exactly once per completed operation, and only after command 0x70 has been latched. ioOe is low while reN is low.
- R5: After the status pulse, done is high for one cycle. At that point statusFail equals I/O0 as sampled during the reN low phase, where 0 means pass and 1 means fail. done, rejected and timeoutErr are never high together.
- R6: A request whose bit 14 differs between srcAddr and dstAddr gets a one-cycle rejected pulse in the next cycle. No strobe moves and busy stays low.
- R7: If rbN stays low for TIMEOUT cycles in a wait, timeoutErr pulses for one cycle and busy drops in that same cycle. No further byte is sent.
- R8: Once the three destination address bytes have been sent, that destination page (bits 24..9) is recorded. With checkValid high, a checkAddr in a recorded page sets hazard high, whatever the value of bits 8..0.
- R9: hazard is low for any page that has not been recorded, and it is low whenever checkValid is low.
- R10: A one-cycle eraseValid clears every recorded page whose block bits 24..14 match eraseAddr. Entries for other blocks are kept.
- R11: weN is low for exactly PULSE_W cycles in each byte. reN is also low for exactly PULSE_W cycles.
- R12: After reset and whenever busy is low, weN and reN are high and cle, ale and ioOe are low. cle and ale are never high together.
- R13: A reqValid that arrives while busy is high is ignored. The running operation keeps its addresses and finishes once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Copy request, sampled while idle |
| srcAddr | input | 25 | Source byte address |
| dstAddr | input | 25 | Destination byte address |
| rbN | input | 1 | Device ready (1) / busy (0) |
| ioIn | input | 8 | Bus read data |
| ioOut | output | 8 | Bus write data |
| ioOe | output | 1 | Bus output enable |
| cle | output | 1 | Command latch strobe |
| ale | output | 1 | Address latch strobe |
| weN | output | 1 | Write enable, active low |
| reN | output | 1 | Read enable, active low |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished, result valid |
| statusFail | output | 1 | Program result, 1 = fail |
| rejected | output | 1 | Request refused, plane mismatch |
| timeoutErr | output | 1 | Ready never returned |
| checkValid | input | 1 | Partial-program check request |
| checkAddr | input | 25 | Address of the page to check |
| eraseValid | input | 1 | Block erased notification |
| eraseAddr | input | 25 | Address inside the erased block |
| hazard | output | 1 | Checked page was a copy-back destination |

## Verification
A step counter that is off by one shows on the bus at once. A byte is repeated or skipped, or a wait phase starts in the wrong place, and this appears at the very next weN rising edge as a wrong byte, a wrong cle/ale pairing or a wrong byte count. A phase counter that drifts changes the measured width of the weN or reN low phase within one byte time. A wait that exits too early shows as command 0x8A latched while rbN is still low. A destination table that forgets an entry or wipes the wrong one only shows when the host next queries that page. For this reason hazard is probed right after recording and right after erasing.

// File: rtl/cbk_pkg.sv
package cbk_pkg;
  localparam logic [7:0] CMD_PAGE_READ = 8'h00;
  localparam logic [7:0] CMD_COPY_PROG = 8'h8A;
  localparam logic [7:0] CMD_STATUS    = 8'h70;

  localparam int STEP_W = 4;
  localparam logic [STEP_W-1:0] STEP_RD_CMD  = 4'd0;
  localparam logic [STEP_W-1:0] STEP_RD_LAST = 4'd3;
  localparam logic [STEP_W-1:0] STEP_PG_CMD  = 4'd4;
  localparam logic [STEP_W-1:0] STEP_PG_LAST = 4'd7;
  localparam logic [STEP_W-1:0] STEP_ST_CMD  = 4'd8;

  typedef struct packed {
    logic              load;    // capture request addresses
    logic [STEP_W-1:0] step;    // which bus byte is current
    logic              sample;  // capture status bit
    logic              record;  // destination address fully sent
  } cbkStrobe_t;
endpackage

// File: rtl/cbk_ctrl.sv
module cbk_ctrl
  import cbk_pkg::*;
#(
  parameter int PULSE_W    = 2,
  parameter int WAIT_BLIND = 2,
  parameter int TIMEOUT    = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       planeMatch,
  input  logic       rbN,
  output cbkStrobe_t strb,
  output logic       cle,
  output logic       ale,
  output logic       weN,
  output logic       reN,
  output logic       ioOe,
  output logic       busy,
  output logic       done,
  output logic       rejected,
  output logic       timeoutErr
);
  localparam int CW = $clog2(TIMEOUT + 2*PULSE_W + WAIT_BLIND + 1);
  localparam logic [CW-1:0] PULSE_C = CW'(PULSE_W);
  localparam logic [CW-1:0] BYTE_LAST = CW'(2*PULSE_W - 1);
  localparam logic [CW-1:0] BLIND_C = CW'(WAIT_BLIND);
  localparam logic [CW-1:0] TO_LAST = CW'(TIMEOUT - 1);

  typedef enum logic [2:0] {S_IDLE, S_BYTE, S_WAIT, S_READ, S_FINISH} state_t;

  state_t state;
  logic [STEP_W-1:0] step;
  logic [CW-1:0] cnt;
  logic isCmd, inByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      step <= '0;
      cnt <= '0;
      rejected <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      rejected <= 1'b0;
      timeoutErr <= 1'b0;
      unique case (state)
        S_IDLE: if (reqValid) begin
          if (planeMatch) begin
            state <= S_BYTE;
            step <= STEP_RD_CMD;
            cnt <= '0;
          end else begin
            rejected <= 1'b1;
          end
        end
        S_BYTE: begin
          if (cnt == BYTE_LAST) begin
            cnt <= '0;
            if (step == STEP_RD_LAST || step == STEP_PG_LAST) state <= S_WAIT;
            else if (step == STEP_ST_CMD) state <= S_READ;
            else step <= step + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WAIT: begin
          if (cnt >= BLIND_C && rbN) begin
            state <= S_BYTE;
            step <= step + 1'b1;
            cnt <= '0;
          end else if (cnt == TO_LAST) begin
            state <= S_IDLE;
            timeoutErr <= 1'b1;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_READ: begin
          if (cnt == BYTE_LAST) begin
            state <= S_FINISH;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_FINISH: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    inByte = (state == S_BYTE);
    isCmd = (step == STEP_RD_CMD) || (step == STEP_PG_CMD) || (step == STEP_ST_CMD);
    cle = inByte && isCmd;
    ale = inByte && !isCmd;
    ioOe = inByte;
    weN = !(inByte && cnt < PULSE_C);
    reN = !(state == S_READ && cnt < PULSE_C);
    busy = (state != S_IDLE);
    done = (state == S_FINISH);
    strb.load = (state == S_IDLE) && reqValid && planeMatch;
    strb.step = step;
    strb.sample = (state == S_READ) && (cnt == PULSE_C - 1'b1);
    strb.record = inByte && (step == STEP_PG_LAST) && (cnt == BYTE_LAST);
  end
endmodule

// File: rtl/cbk_datapath.sv
module cbk_datapath
  import cbk_pkg::*;
#(
  parameter int ADDR_W    = 25,
  parameter int DEPTH     = 4,
  parameter int PLANE_BIT = 14,
  parameter int PAGE_LSB  = 9,
  parameter int BLOCK_LSB = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  cbkStrobe_t        strb,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [7:0]        ioIn,
  input  logic              checkValid,
  input  logic [ADDR_W-1:0] checkAddr,
  input  logic              eraseValid,
  input  logic [ADDR_W-1:0] eraseAddr,
  output logic [7:0]        ioOut,
  output logic              planeMatch,
  output logic              statusFail,
  output logic              hazard
);
  localparam int PAGE_W = ADDR_W - PAGE_LSB;
  localparam int BLK_OFS = BLOCK_LSB - PAGE_LSB;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ADDR_W-1:0] srcQ, dstQ;
  logic [PAGE_W-1:0] pageQ [DEPTH];
  logic [DEPTH-1:0] validQ, hit;
  logic [PW-1:0] wp;
  logic unusedBits;

  assign planeMatch = (srcAddr[PLANE_BIT] == dstAddr[PLANE_BIT]);
  assign unusedBits = ^{ioIn[7:1], checkAddr[PAGE_LSB-1:0], eraseAddr[BLOCK_LSB-1:0]};

  function automatic logic [7:0] addrByte(input logic [ADDR_W-1:0] a, input int k);
    unique case (k)
      0: return a[7:0];
      1: return a[16:9];
      default: return a[24:17];
    endcase
  endfunction

  always_comb begin
    unique case (strb.step)
      4'd0: ioOut = CMD_PAGE_READ;
      4'd1: ioOut = addrByte(srcQ, 0);
      4'd2: ioOut = addrByte(srcQ, 1);
      4'd3: ioOut = addrByte(srcQ, 2);
      4'd4: ioOut = CMD_COPY_PROG;
      4'd5: ioOut = addrByte(dstQ, 0);
      4'd6: ioOut = addrByte(dstQ, 1);
      4'd7: ioOut = addrByte(dstQ, 2);
      default: ioOut = CMD_STATUS;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ <= '0;
      dstQ <= '0;
      statusFail <= 1'b0;
    end else begin
      if (strb.load) begin
        srcQ <= srcAddr;
        dstQ <= dstAddr;
      end
      if (strb.sample) statusFail <= ioIn[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wp <= '0;
      validQ <= '0;
      for (int i = 0; i < DEPTH; i++) pageQ[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (strb.record && wp == PW'(i)) begin
          pageQ[i] <= dstQ[ADDR_W-1:PAGE_LSB];
          validQ[i] <= 1'b1;
        end else if (eraseValid && pageQ[i][PAGE_W-1:BLK_OFS] == eraseAddr[ADDR_W-1:BLOCK_LSB]) begin
          validQ[i] <= 1'b0;
        end
      end
      if (strb.record) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_hit
    assign hit[i] = validQ[i] && (pageQ[i] == checkAddr[ADDR_W-1:PAGE_LSB]);
  end

  assign hazard = checkValid && (|hit);
endmodule

// File: rtl/nand_copyback_seq.sv
module nand_copyback_seq
  import cbk_pkg::*;
#(
  parameter int ADDR_W     = 25,
  parameter int PULSE_W    = 2,
  parameter int WAIT_BLIND = 2,
  parameter int TIMEOUT    = 4096,
  parameter int DEPTH      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic              rbN,
  input  logic [7:0]        ioIn,
  output logic [7:0]        ioOut,
  output logic              ioOe,
  output logic              cle,
  output logic              ale,
  output logic              weN,
  output logic              reN,
  output logic              busy,
  output logic              done,
  output logic              statusFail,
  output logic              rejected,
  output logic              timeoutErr,
  input  logic              checkValid,
  input  logic [ADDR_W-1:0] checkAddr,
  input  logic              eraseValid,
  input  logic [ADDR_W-1:0] eraseAddr,
  output logic              hazard
);
  cbkStrobe_t strb;
  logic planeMatch;

  cbk_ctrl #(.PULSE_W(PULSE_W), .WAIT_BLIND(WAIT_BLIND), .TIMEOUT(TIMEOUT)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .planeMatch(planeMatch), .rbN(rbN),
    .strb(strb), .cle(cle), .ale(ale), .weN(weN), .reN(reN), .ioOe(ioOe),
    .busy(busy), .done(done), .rejected(rejected), .timeoutErr(timeoutErr)
  );

  cbk_datapath #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .srcAddr(srcAddr), .dstAddr(dstAddr),
    .ioIn(ioIn), .checkValid(checkValid), .checkAddr(checkAddr),
    .eraseValid(eraseValid), .eraseAddr(eraseAddr), .ioOut(ioOut),
    .planeMatch(planeMatch), .statusFail(statusFail), .hazard(hazard)
  );
endmodule

// File: rtl/cbk_checker.sv
module cbk_checker (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] ioOut,
  input logic       ioOe,
  input logic       cle,
  input logic       ale,
  input logic       weN,
  input logic       reN,
  input logic       busy,
  input logic       done,
  input logic       rejected,
  input logic       timeoutErr
);
  p_latch_excl_r12: assert property (@(posedge clk) disable iff (!rstN) !(cle && ale));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (weN && reN && !cle && !ale && !ioOe));

  p_reject_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    rejected |-> (!busy && weN && !cle && !ale));

  p_read_no_drive_r4: assert property (@(posedge clk) disable iff (!rstN)
    !reN |-> (!ioOe && weN));

  p_one_result_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, rejected, timeoutErr}));

  p_timeout_exit_r7: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> !busy);

  p_byte_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!weN && !$past(weN)) |-> $stable(ioOut));
endmodule

bind nand_copyback_seq cbk_checker i_cbk_checker (
  .clk(clk), .rstN(rstN), .ioOut(ioOut), .ioOe(ioOe), .cle(cle), .ale(ale),
  .weN(weN), .reN(reN), .busy(busy), .done(done), .rejected(rejected),
  .timeoutErr(timeoutErr)
);

// File: tb/test_nand_copyback_seq.sv
module test_nand_copyback_seq;
  localparam int CLK_PERIOD = 10;
  localparam int P = 2;
  localparam int BLIND = 2;
  localparam int TO = 64;
  localparam int BUSY_LEN = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [24:0] srcAddr = '0, dstAddr = '0, checkAddr = '0, eraseAddr = '0;
  logic rbN = 1'b1;
  logic [7:0] ioIn = 8'h00;
  logic checkValid = 1'b0, eraseValid = 1'b0;
  logic [7:0] ioOut;
  logic ioOe, cle, ale, weN, reN, busy, done, statusFail, rejected, timeoutErr, hazard;

  nand_copyback_seq #(.PULSE_W(P), .WAIT_BLIND(BLIND), .TIMEOUT(TO)) i_nand_copyback_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .srcAddr(srcAddr), .dstAddr(dstAddr),
    .rbN(rbN), .ioIn(ioIn), .ioOut(ioOut), .ioOe(ioOe), .cle(cle), .ale(ale),
    .weN(weN), .reN(reN), .busy(busy), .done(done), .statusFail(statusFail),
    .rejected(rejected), .timeoutErr(timeoutErr), .checkValid(checkValid),
    .checkAddr(checkAddr), .eraseValid(eraseValid), .eraseAddr(eraseAddr), .hazard(hazard)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  bit finished = 1'b0;
  logic [9:0] got[$];
  int invErr = 0, widthErr = 0, rbErr = 0, reErr = 0, reCount = 0;
  int weLow = 0, reLow = 0, addrCnt = 0, busyCnt = 0;
  logic [7:0] lastCmd = 8'hFF;
  logic prevWe = 1'b1, prevRe = 1'b1;
  bit stuck = 1'b0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [24:0] mkAddr(input logic [9:0] hi, input logic plane,
                                         input logic [4:0] pg, input logic a8, input logic [7:0] lo);
    return {hi, plane, pg, a8, lo};
  endfunction

  // Device and bus monitor: one behavioural step per clock, sampled on the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      if (!busy && (!weN || !reN || cle || ale || ioOe)) invErr++;
      if (cle && ale) invErr++;
      if (!weN) weLow++;
      if (weN && !prevWe) begin
        if (weLow != P) widthErr++;
        weLow = 0;
        got.push_back({cle, ale, ioOut});
        if (cle && ioOut == 8'h8A && !rbN) rbErr++;
        if (cle) begin
          lastCmd = ioOut;
          addrCnt = 0;
        end else if (ale) begin
          addrCnt++;
          if (addrCnt == 3 && (lastCmd == 8'h00 || lastCmd == 8'h8A)) begin
            rbN = 1'b0;
            busyCnt = BUSY_LEN;
          end
        end
      end
      if (!reN && prevRe && lastCmd != 8'h70) reErr++;
      if (!reN) reLow++;
      if (reN && !prevRe) begin
        reCount++;
        if (reLow != P) widthErr++;
        reLow = 0;
      end
      if (!rbN && !stuck) begin
        if (busyCnt > 0) busyCnt--;
        else rbN = 1'b1;
      end
      prevWe = weN;
      prevRe = reN;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  task automatic runCopy(input logic [24:0] s, input logic [24:0] d, input logic failBit,
                         input bit poke, output bit sawDone, output logic resFail, output int reDelta);
    logic [9:0] exp[9];
    int re0;
    exp[0] = {2'b10, 8'h00};
    exp[1] = {2'b01, s[7:0]};
    exp[2] = {2'b01, s[16:9]};
    exp[3] = {2'b01, s[24:17]};
    exp[4] = {2'b10, 8'h8A};
    exp[5] = {2'b01, d[7:0]};
    exp[6] = {2'b01, d[16:9]};
    exp[7] = {2'b01, d[24:17]};
    exp[8] = {2'b10, 8'h70};
    got.delete();
    re0 = reCount;
    ioIn = {7'd0, failBit};
    sawDone = 1'b0;
    resFail = 1'b0;
    @(negedge clk);
    srcAddr = s;
    dstAddr = d;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (poke && i == 5) begin
        srcAddr = ~s;
        dstAddr = ~d;
        reqValid = 1'b1;
      end else begin
        reqValid = 1'b0;
      end
      if (done) begin
        sawDone = 1'b1;
        resFail = statusFail;
        break;
      end
    end
    reqValid = 1'b0;
    reDelta = reCount - re0;
    check(got.size() == 9, "R1", "byte count", got.size(), 9);
    for (int k = 0; k < 9 && k < got.size(); k++)
      check(got[k] == exp[k], (k == 0 || k == 4 || k == 8) ? "R1" : "R2",
            $sformatf("byte %0d", k), got[k], exp[k]);
  endtask

  initial begin
    bit sd;
    logic rf;
    int rd;
    logic [24:0] d1, d2, s1, s2;
    s1 = mkAddr(10'h2B5, 1'b1, 5'h0A, 1'b1, 8'h3C);
    d1 = mkAddr(10'h1C2, 1'b1, 5'h11, 1'b0, 8'h00);
    s2 = mkAddr(10'h0F0, 1'b0, 5'h03, 1'b1, 8'hA5);
    d2 = mkAddr(10'h333, 1'b0, 5'h1F, 1'b0, 8'h00);

    repeat (3) @(negedge clk);
    check(weN && reN && !cle && !ale && !ioOe && !busy && !done, "R12", "reset strobes",
          {weN, reN, cle, ale, ioOe, busy, done}, 7'b1100000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // normal pass copy
    runCopy(s1, d1, 1'b0, 1'b0, sd, rf, rd);
    check(sd, "R5", "done pulse", sd, 1);
    check(rf == 1'b0, "R5", "pass status", rf, 0);
    check(rd == 1, "R4", "one RE pulse", rd, 1);
    repeat (20) @(negedge clk);

    // failing copy with a request poked in while busy
    runCopy(s2, d2, 1'b1, 1'b1, sd, rf, rd);
    check(sd, "R13", "done despite poke", sd, 1);
    check(rf == 1'b1, "R5", "fail status", rf, 1);
    got.delete();
    repeat (40) @(negedge clk);
    check(got.size() == 0 && !busy, "R13", "no second op", got.size(), 0);

    // plane mismatch
    got.delete();
    srcAddr = mkAddr(10'h111, 1'b0, 5'h01, 1'b0, 8'h00);
    dstAddr = mkAddr(10'h111, 1'b1, 5'h01, 1'b0, 8'h00);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(rejected && !busy, "R6", "rejected pulse", {rejected, busy}, 2'b10);
    @(negedge clk);
    check(!rejected, "R6", "reject one cycle", rejected, 0);
    repeat (20) @(negedge clk);
    check(got.size() == 0 && !busy, "R6", "no strobes on reject", got.size(), 0);

    // stuck busy
    stuck = 1'b1;
    got.delete();
    srcAddr = mkAddr(10'h055, 1'b1, 5'h02, 1'b0, 8'h10);
    dstAddr = mkAddr(10'h077, 1'b1, 5'h04, 1'b0, 8'h00);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    sd = 1'b0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (timeoutErr) begin
        sd = 1'b1;
        check(!busy, "R7", "busy drops with timeout", busy, 0);
        break;
      end
    end
    check(sd, "R7", "timeout flagged", sd, 1);
    repeat (30) @(negedge clk);
    check(got.size() == 4 && !busy, "R7", "nothing after timeout", got.size(), 4);
    stuck = 1'b0;
    repeat (30) @(negedge clk);

    // destination table
    checkValid = 1'b1;
    checkAddr = {d1[24:9], 1'b1, 8'hEE};
    #(CLK_PERIOD/4);
    check(hazard, "R8", "d1 recorded", hazard, 1);
    checkAddr = d2;
    #(CLK_PERIOD/4);
    check(hazard, "R8", "d2 recorded (failed program)", hazard, 1);
    checkAddr = mkAddr(10'h1C2, 1'b1, 5'h12, 1'b0, 8'h00);
    #(CLK_PERIOD/4);
    check(!hazard, "R9", "neighbour page clear", hazard, 0);
    checkAddr = mkAddr(10'h077, 1'b1, 5'h04, 1'b0, 8'h00);
    #(CLK_PERIOD/4);
    check(!hazard, "R9", "timed-out dst not recorded", hazard, 0);
    checkValid = 1'b0;
    checkAddr = d1;
    #(CLK_PERIOD/4);
    check(!hazard, "R9", "gated by checkValid", hazard, 0);

    @(negedge clk);
    eraseAddr = {d1[24:14], 14'h1234};
    eraseValid = 1'b1;
    @(negedge clk);
    eraseValid = 1'b0;
    checkValid = 1'b1;
    checkAddr = d1;
    #(CLK_PERIOD/4);
    check(!hazard, "R10", "erased block cleared", hazard, 0);
    checkAddr = d2;
    #(CLK_PERIOD/4);
    check(hazard, "R10", "other block kept", hazard, 1);
    checkValid = 1'b0;

    @(negedge clk);
    check(widthErr == 0, "R11", "strobe widths", widthErr, 0);
    check(invErr == 0, "R12", "idle strobe invariants", invErr, 0);
    check(rbErr == 0, "R3", "8A latched while busy", rbErr, 0);
    check(reErr == 0, "R4", "RE before status cmd", reErr, 0);
    summary();
  end
endmodule